// File: doc/BRIEF.md
# Chained Node Status Summary Tree

This block gathers one status flag from each of up to 64 networked nodes and folds them into a single request-for-service output. The flags are spread over five 16-bit register sets. Each set holds three registers: condition, which shows the live input levels; event, which latches rising edges; and enable, which is a mask. Bits 1 to 14 of a set each belong to one node. Bit 0 of a set is an extension flag that is driven by the enabled summary of the next set in the chain, so the last set feeds the fourth set, the fourth feeds the third, and so on up to the first set.

The enabled summary of the first set is the request-for-service output. A small access port lets software do three things: write the enable masks, read any register, and clear an event register by reading it. With the right masks, a rising edge on any node climbs the chain one set per clock and raises the request.

Top module: `node_status_tree`

## Requirements
- R1: After reset, every condition, event and enable register reads zero, the read data output is zero and `rqs_o` is low.
- R2: Set select values 0 to 4 address sets 1 to 5. Register select 0 is condition, 1 is event, 2 is enable, and 3 always reads zero. Bit b (1 to 14) of set s maps to node input s*14+b-1, so node input 63 lands in bit 8 of set 5 and node input 50 lands in bit 9 of set 4.
- R3: A condition register read returns the node input levels present in the cycle of the read strobe.
- R4: An event bit sets on a rising edge of its condition bit and stays set after the condition falls.
- R5: Reading an event register returns its contents and clears that register only.
- R6: If a read-clear and a new rising edge hit the same event register in the same cycle, the newly risen bit stays set and all other bits clear.
- R7: A one-cycle global clear pulse empties the event registers of all five sets.
- R8: Only enable registers accept writes. Writes to condition or event registers, and writes with a set select of 5 to 7, change nothing.
- R9: Bit 15 of every register reads zero. In set 5, bits 9 to 15 read zero whatever is written.
- R10: The extension bit of a set latches when the OR of event AND enable of the next set rises. `rqs_o` is the OR of event AND enable in set 1. A node edge in set 5 reaches `rqs_o` after five clock edges, and a masked event does not propagate.
- R11: Read data appears on the clock edge that samples the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| node_cond_i | input | 64 | Per-node status levels |
| clr_all_i | input | 1 | Clears every event register |
| acc_set_i | input | 3 | Register set select |
| acc_reg_i | input | 2 | Register select within the set |
| acc_wr_i | input | 1 | Write strobe (enable registers only) |
| acc_rd_i | input | 1 | Read strobe |
| acc_wdata_i | input | 16 | Write data |
| acc_rdata_o | output | 16 | Registered read data |
| rqs_o | output | 1 | Request-for-service summary |

## Verification
Two situations are hard to reach. The first is a read-clear that lands in the same cycle as a fresh edge. To get there, the stimulus first latches an unrelated event, then raises a second node in the very cycle it strobes the event read. It then reads again to confirm that only the new bit survives. The second is propagation through all five sets. For that, the stimulus enables only the extension bits along the chain plus one node in set 5, pulses that node, and checks that `rqs_o` is still low after four edges and high after the fifth. A node whose bit is masked is also pulsed, to show that it never reaches the output.

// File: rtl/nst_pkg.sv
package nst_pkg;

   typedef enum logic [1:0] {
      SEL_COND   = 2'd0,
      SEL_EVENT  = 2'd1,
      SEL_ENABLE = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;

   // Bits that exist in set s: the extension bit plus node bits that map to a real node.
   function automatic int unsigned impl_mask(input int s, input int nps, input int nodes);
      int unsigned m;
      m = 1;
      for (int b = 1; b <= nps; b++) begin
         if (s * nps + b - 1 < nodes) m = m | (32'd1 << b);
      end
      return m;
   endfunction

endpackage

// File: rtl/nst_set.sv
module nst_set #(
   parameter int               REG_W = 16,
   parameter logic [REG_W-1:0] MASK  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] cond_i,
   input  logic             clr_i,
   input  logic             wr_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [REG_W-1:0] event_o,
   output logic [REG_W-1:0] enable_o,
   output logic             summary_o
);
   logic [REG_W-1:0] cond_q;
   logic [REG_W-1:0] ev_q;
   logic [REG_W-1:0] en_q;
   logic [REG_W-1:0] rise_w;

   assign rise_w = cond_i & ~cond_q & MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_q <= '0;
         ev_q   <= '0;
         en_q   <= '0;
      end else begin
         cond_q <= cond_i & MASK;
         // a fresh edge survives a clear in the same cycle
         ev_q   <= (clr_i ? '0 : ev_q) | rise_w;
         if (wr_i) en_q <= wdata_i & MASK;
      end
   end

   assign event_o   = ev_q;
   assign enable_o  = en_q;
   assign summary_o = |(ev_q & en_q);
endmodule

// File: rtl/node_status_tree.sv
module node_status_tree
   import nst_pkg::*;
#(
   parameter int NODES     = 64,
   parameter int REG_W     = 16,
   parameter int NUM_SETS  = 5,
   parameter int SET_SEL_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NODES-1:0]     node_cond_i,
   input  logic                 clr_all_i,
   input  logic [SET_SEL_W-1:0] acc_set_i,
   input  logic [1:0]           acc_reg_i,
   input  logic                 acc_wr_i,
   input  logic                 acc_rd_i,
   input  logic [REG_W-1:0]     acc_wdata_i,
   output logic [REG_W-1:0]     acc_rdata_o,
   output logic                 rqs_o
);
   localparam int NPS = REG_W - 2;

   if (NUM_SETS * NPS < NODES) begin : g_err_cover
      $error("node_status_tree: sets cannot hold all nodes");
   end
   if (NUM_SETS > (1 << SET_SEL_W)) begin : g_err_sel
      $error("node_status_tree: set select too narrow");
   end
   if (REG_W > 32 || REG_W < 3) begin : g_err_width
      $error("node_status_tree: register width out of range");
   end

   logic [NUM_SETS-1:0][REG_W-1:0] cond_w;
   logic [NUM_SETS-1:0][REG_W-1:0] ev_w;
   logic [NUM_SETS-1:0][REG_W-1:0] en_w;
   logic [NUM_SETS-1:0]            sum_w;
   logic [NUM_SETS-1:0]            clr_w;
   logic [NUM_SETS-1:0]            wr_w;
   logic [REG_W-1:0]               rd_val;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      localparam logic [REG_W-1:0] MASK = REG_W'(impl_mask(s, NPS, NODES));

      // extension bit: fed by the next set, tied off at the end of the chain
      if (s == NUM_SETS - 1) begin : g_tail
         assign cond_w[s][0] = 1'b0;
      end else begin : g_link
         assign cond_w[s][0] = sum_w[s+1];
      end

      for (genvar b = 1; b < REG_W; b++) begin : g_bit
         localparam int IDX = s * NPS + b - 1;
         if (b <= NPS && IDX < NODES) begin : g_node
            assign cond_w[s][b] = node_cond_i[IDX];
         end else begin : g_unused
            assign cond_w[s][b] = 1'b0;
         end
      end

      assign clr_w[s] = clr_all_i |
                        (acc_rd_i && acc_set_i == SET_SEL_W'(s) && acc_reg_i == SEL_EVENT);
      assign wr_w[s]  = acc_wr_i && acc_set_i == SET_SEL_W'(s) && acc_reg_i == SEL_ENABLE;

      nst_set #(
         .REG_W (REG_W),
         .MASK  (MASK)
      ) i_set (
         .clk       (clk),
         .rst_n     (rst_n),
         .cond_i    (cond_w[s]),
         .clr_i     (clr_w[s]),
         .wr_i      (wr_w[s]),
         .wdata_i   (acc_wdata_i),
         .event_o   (ev_w[s]),
         .enable_o  (en_w[s]),
         .summary_o (sum_w[s])
      );
   end

   assign rqs_o = sum_w[0];

   always_comb begin
      rd_val = '0;
      for (int s = 0; s < NUM_SETS; s++) begin
         if (acc_set_i == SET_SEL_W'(s)) begin
            case (acc_reg_i)
               SEL_COND:   rd_val = cond_w[s];
               SEL_EVENT:  rd_val = ev_w[s];
               SEL_ENABLE: rd_val = en_w[s];
               default:    rd_val = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        acc_rdata_o <= '0;
      else if (acc_rd_i) acc_rdata_o <= rd_val;
   end
endmodule

// File: rtl/nst_checker.sv
module nst_checker #(
   parameter int NODES     = 64,
   parameter int REG_W     = 16,
   parameter int NUM_SETS  = 5,
   parameter int SET_SEL_W = 3
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           node0_i,
   input logic [SET_SEL_W-1:0]           acc_set_i,
   input logic [1:0]                     acc_reg_i,
   input logic                           acc_rd_i,
   input logic [REG_W-1:0]               acc_rdata_o,
   input logic [NUM_SETS-1:0][REG_W-1:0] ev_w,
   input logic [NUM_SETS-1:0][REG_W-1:0] en_w,
   input logic [NUM_SETS-1:0]            clr_w
);
   localparam int NPS       = REG_W - 2;
   localparam int LAST_BITS = NODES - (NUM_SETS - 1) * NPS;
   localparam logic [REG_W-1:0] LAST_KEEP = REG_W'((64'd1 << (LAST_BITS + 1)) - 64'd1);

   AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_rdata_o[REG_W-1]); // R9

   AST_LAST_SET_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_w[NUM_SETS-1] | en_w[NUM_SETS-1]) & ~LAST_KEEP) == '0); // R9

   AST_LAST_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_w[NUM_SETS-1][0]); // R10

   AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(node0_i) |=> ev_w[0][1]); // R6

   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd_i && acc_set_i == '0 && acc_reg_i == 2'd1) |=> acc_rdata_o == $past(ev_w[0])); // R11

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_chk
      AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         !clr_w[s] |=> ((ev_w[s] & $past(ev_w[s])) == $past(ev_w[s]))); // R4
      if (s < NUM_SETS - 1) begin : g_link
         AST_EXT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ev_w[s][0]) |-> $past(|(ev_w[s+1] & en_w[s+1]))); // R10
      end
   end
endmodule

bind node_status_tree nst_checker #(
   .NODES     (NODES),
   .REG_W     (REG_W),
   .NUM_SETS  (NUM_SETS),
   .SET_SEL_W (SET_SEL_W)
) i_nst_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .node0_i     (node_cond_i[0]),
   .acc_set_i   (acc_set_i),
   .acc_reg_i   (acc_reg_i),
   .acc_rd_i    (acc_rd_i),
   .acc_rdata_o (acc_rdata_o),
   .ev_w        (ev_w),
   .en_w        (en_w),
   .clr_w       (clr_w)
);

// File: tb/test_node_status_tree.sv
`timescale 1ns/1ps
module test_node_status_tree;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] node_cond = '0;
   logic        clr_all = 1'b0;
   logic [2:0]  acc_set = '0;
   logic [1:0]  acc_reg = '0;
   logic        acc_wr = 1'b0;
   logic        acc_rd = 1'b0;
   logic [15:0] acc_wdata = '0;
   logic [15:0] acc_rdata;
   logic        rqs;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      logic [15:0] exp;
      string       tag;
   } item_t;
   item_t sb_q[$];

   always #4 clk = ~clk;

   node_status_tree i_node_status_tree (
      .clk         (clk),
      .rst_n       (rst_n),
      .node_cond_i (node_cond),
      .clr_all_i   (clr_all),
      .acc_set_i   (acc_set),
      .acc_reg_i   (acc_reg),
      .acc_wr_i    (acc_wr),
      .acc_rd_i    (acc_rd),
      .acc_wdata_i (acc_wdata),
      .acc_rdata_o (acc_rdata),
      .rqs_o       (rqs)
   );

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int s, input int r, input logic [15:0] d);
      acc_set = 3'(s); acc_reg = 2'(r); acc_wdata = d; acc_wr = 1'b1;
      @(negedge clk);
      acc_wr = 1'b0;
   endtask

   // driver: pushes the expected word, strobes the read
   task automatic rd(input int s, input int r, input logic [15:0] e, input string tag);
      item_t it;
      it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      acc_set = 3'(s); acc_reg = 2'(r); acc_rd = 1'b1;
      @(negedge clk);
      acc_rd = 1'b0;
   endtask

   // monitor: pops and compares one cycle after each sampled strobe
   initial begin
      forever begin
         bit fire;
         @(posedge clk);
         fire = acc_rd;
         @(negedge clk);
         if (fire) begin
            if (sb_q.size() == 0) begin
               chk(acc_rdata, 16'hxxxx, "R11 unexpected read");
            end else begin
               item_t it;
               it = sb_q.pop_front();
               chk(acc_rdata, it.exp, it.tag);
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog (all requirements): actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk(acc_rdata, 16'h0000, "R1 rdata");
      chk({15'b0, rqs}, 16'h0000, "R1 rqs");
      rd(0, 1, 16'h0000, "R1 event");
      rd(0, 2, 16'h0000, "R1 enable");
      rd(2, 0, 16'h0000, "R1 cond");

      // R9 masking of unused bits, R8 ignored writes
      wr(0, 2, 16'hFFFF);
      rd(0, 2, 16'h7FFF, "R9 bit15");
      wr(4, 2, 16'hFFFF);
      rd(4, 2, 16'h01FF, "R9 set5 top bits");
      wr(4, 2, 16'h0000);
      rd(4, 2, 16'h0000, "R8 enable rewrite");
      wr(1, 0, 16'hFFFF);
      wr(1, 1, 16'hFFFF);
      wr(5, 2, 16'hFFFF);
      rd(1, 0, 16'h0000, "R8 cond write ignored");
      rd(1, 1, 16'h0000, "R8 event write ignored");
      rd(1, 2, 16'h0000, "R8 set1 enable");
      rd(0, 2, 16'h7FFF, "R8 sel5 ignored");
      rd(0, 3, 16'h0000, "R2 reserved select");

      // R2 / R3 mapping and live condition
      node_cond[0] = 1'b1; node_cond[14] = 1'b1; node_cond[63] = 1'b1;
      rd(0, 0, 16'h0002, "R3 set1 cond");
      rd(1, 0, 16'h0002, "R2 node15 in set2");
      rd(4, 0, 16'h0100, "R2 node64 in set5");
      chk({15'b0, rqs}, 16'h0001, "R10 set1 enabled event");
      node_cond = '0;
      rd(0, 0, 16'h0000, "R3 cond falls");
      rd(1, 1, 16'h0002, "R4 event held");
      rd(1, 1, 16'h0000, "R5 read cleared");
      rd(4, 1, 16'h0100, "R5 other set untouched");
      rd(0, 1, 16'h0002, "R5 set1 event");
      chk({15'b0, rqs}, 16'h0000, "R5 rqs after clear");

      // R6 collision of clear and new edge
      node_cond[2] = 1'b1;
      idle(1);
      node_cond[2] = 1'b0;
      node_cond[1] = 1'b1;
      rd(0, 1, 16'h0008, "R6 old contents");
      rd(0, 1, 16'h0004, "R6 edge wins");
      node_cond[1] = 1'b0;
      rd(0, 1, 16'h0000, "R6 cleared after");

      // R7 global clear
      node_cond[20] = 1'b1; node_cond[30] = 1'b1;
      idle(1);
      node_cond = '0;
      clr_all = 1'b1;
      idle(1);
      clr_all = 1'b0;
      rd(1, 1, 16'h0000, "R7 set2 cleared");
      rd(2, 1, 16'h0000, "R7 set3 cleared");

      // R10 chain propagation
      wr(0, 2, 16'h0001);
      wr(1, 2, 16'h0001);
      wr(2, 2, 16'h0001);
      wr(3, 2, 16'h0001);
      wr(4, 2, 16'h0100);
      chk({15'b0, rqs}, 16'h0000, "R10 idle");
      node_cond[50] = 1'b1;
      idle(1);
      node_cond[50] = 1'b0;
      idle(6);
      chk({15'b0, rqs}, 16'h0000, "R10 masked event");
      rd(3, 1, 16'h0200, "R2 node51 in set4");
      node_cond[63] = 1'b1;
      idle(4);
      chk({15'b0, rqs}, 16'h0000, "R10 after four edges");
      idle(1);
      chk({15'b0, rqs}, 16'h0001, "R10 after five edges");
      node_cond[63] = 1'b0;
      rd(0, 0, 16'h0001, "R10 extension cond");
      rd(2, 1, 16'h0001, "R10 middle extension");
      chk({15'b0, rqs}, 16'h0001, "R4 upper set still latched");

      // R11 hold between reads
      rd(4, 2, 16'h0100, "R11 read");
      idle(3);
      chk(acc_rdata, 16'h0100, "R11 hold");

      idle(2);
      if (sb_q.size() != 0) chk(16'(sb_q.size()), 16'h0000, "R11 pending reads");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule